// File: doc/BRIEF.md
# Tree-Reduction Operand Schedule Generator

This block drives an in-place binary tree reduction over a vector held in a register file. After a start pulse, it takes a 5-bit dimension value and works on a vector of N = dimension + 1 elements. It first runs a counting pass that walks the whole schedule without emitting anything. This pass yields the exact number of operations, which a vector-length register can be loaded with. The block then streams the same schedule as operand index pairs over a ready/valid output.

Every emitted operation names a left element and a right element. The arithmetic unit combines the two and writes the result back over the left element. The schedule works in passes. The stride starts at one and doubles from pass to pass. Within a pass, the left index steps by twice the stride. This keeps each partial result in the lowest index of its group, so element 0 holds the reduction at the end. The block also drives fixed role and mode codes so that a downstream index remapper can tag the two operand streams.

Top module: `tree_reduce_sched`

## Requirements
- R1: The element count N equals the 5-bit `cfgDim` captured at the start pulse plus one. When `countValid` is high, the 7-bit `opCount` equals the number of operations the schedule holds, which is N-1. A change of `cfgDim` after the start pulse has no effect on the run.
- R2: Pairs come out pass by pass. The stride is 1, 2, 4, and so on, and a pass runs only while the stride is unsigned-less-than N. Within a pass the base starts at 0 and rises by twice the stride. A pair is issued only while base + stride < N, with `leftIdx` = base, `rightIdx` = base + stride and `pairStride` = stride.
- R3: `countValid` goes high before the first `pairValid`. `pairValid` is never high while `countValid` is low.
- R4: While `pairValid` is high and `pairReady` is low, the next cycle keeps `pairValid` high. In that cycle `leftIdx`, `rightIdx`, `pairStride` and `pairLast` are unchanged.
- R5: `pairLast` is high on the final pair of the schedule and on no other pair.
- R6: `done` is high for exactly one cycle after the final pair has been accepted. In that cycle `pairValid` and `countValid` are low.
- R7: For N = 1, the block reports `opCount` = 0, raises `countValid`, emits no pair and then raises `done`.
- R8: A start pulse while a run is in progress is ignored: the running schedule and `opCount` are unaffected.
- R9: `leftRole` is 2'b00, `rightRole` is 2'b01 and `modeCode` is 2'b11.
- R10: After reset, `pairValid`, `countValid` and `done` are low and `opCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only when idle |
| cfgDim | input | 5 | Element count minus one |
| pairReady | input | 1 | Consumer accepts the current pair |
| pairValid | output | 1 | An operand pair is presented |
| leftIdx | output | 5 | Left operand and destination index |
| rightIdx | output | 5 | Right operand index |
| pairStride | output | 5 | Stride of the current pass |
| pairLast | output | 1 | Current pair is the final one |
| opCount | output | 7 | Total operation count |
| countValid | output | 1 | `opCount` is final; streaming phase |
| done | output | 1 | One-cycle end-of-run pulse |
| leftRole | output | 2 | Role code of the left operand stream |
| rightRole | output | 2 | Role code of the right operand stream |
| modeCode | output | 2 | Schedule family code |

## Verification
The bench uses the default widths: a 5-bit dimension and a 7-bit count. With these widths, all 32 vector sizes from 1 to 32 elements can be swept exhaustively. Each size is run with a consumer that is always ready and with a pseudo-random stalling consumer. This covers hold under backpressure at every position in the schedule, including pass boundaries and the final pair. For the larger sizes, a third run injects a second start pulse and a new dimension mid-stream, to show that both are ignored.

// File: rtl/tree_reduce_sched_pkg.sv
package tree_reduce_sched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_EMIT  = 2'd2,
    ST_FIN   = 2'd3
  } schedState_t;

  typedef struct packed {
    logic loadCfg;
    logic rewind;
    logic nextPass;
    logic advance;
    logic consume;
    logic incCount;
  } ctlStrobe_t;

  localparam logic [1:0] ROLE_LEFT  = 2'b00;
  localparam logic [1:0] ROLE_RIGHT = 2'b01;
  localparam logic [1:0] MODE_TREE  = 2'b11;

endpackage

// File: rtl/tree_reduce_sched_dp.sv
module tree_reduce_sched_dp
  import tree_reduce_sched_pkg::*;
#(
  parameter int DIM_W   = 5,
  parameter int COUNT_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         stb,
  input  logic [DIM_W-1:0]   cfgDim,
  output logic               opAvail,
  output logic               passAvail,
  output logic [DIM_W-1:0]   leftIdx,
  output logic [DIM_W-1:0]   rightIdx,
  output logic [DIM_W-1:0]   pairStride,
  output logic               pairLast,
  output logic [COUNT_W-1:0] opCount
);

  localparam int W = COUNT_W;

  logic [W-1:0] nReg;
  logic [W-1:0] strideReg;
  logic [W-1:0] baseReg;
  logic [W-1:0] countReg;
  logic [W-1:0] remainReg;
  logic [W:0]   reach;

  assign reach     = {1'b0, baseReg} + {1'b0, strideReg};
  assign opAvail   = reach < {1'b0, nReg};
  assign passAvail = strideReg < nReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nReg      <= W'(1);
      strideReg <= W'(1);
      baseReg   <= '0;
      countReg  <= '0;
      remainReg <= '0;
    end else if (stb.loadCfg) begin
      nReg      <= W'(cfgDim) + W'(1);
      strideReg <= W'(1);
      baseReg   <= '0;
      countReg  <= '0;
      remainReg <= '0;
    end else if (stb.rewind) begin
      strideReg <= W'(1);
      baseReg   <= '0;
      remainReg <= countReg;
    end else if (stb.nextPass) begin
      strideReg <= strideReg << 1;
      baseReg   <= '0;
    end else if (stb.advance) begin
      baseReg <= baseReg + (strideReg << 1);
      if (stb.incCount) countReg  <= countReg + W'(1);
      if (stb.consume)  remainReg <= remainReg - W'(1);
    end
  end

  assign leftIdx    = baseReg[DIM_W-1:0];
  assign rightIdx   = reach[DIM_W-1:0];
  assign pairStride = strideReg[DIM_W-1:0];
  assign pairLast   = (remainReg == W'(1));
  assign opCount    = countReg;

  // R1: the counting walk must land on N-1 operations
  assert_count_exact_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.rewind |=> (countReg == nReg - W'(1)));

  // R2: stride stays a single power of two
  assert_stride_pow2_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strideReg) == 1);

  // R5: never consume past the counted total
  assert_no_underrun_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.consume |-> (remainReg != '0));

endmodule

// File: rtl/tree_reduce_sched_ctrl.sv
module tree_reduce_sched_ctrl
  import tree_reduce_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       pairReady,
  input  logic       opAvail,
  input  logic       passAvail,
  output ctlStrobe_t stb,
  output logic       pairValid,
  output logic       countValid,
  output logic       done
);

  schedState_t state, nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.loadCfg = 1'b1;
          nextState   = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (!passAvail) begin
          stb.rewind = 1'b1;
          nextState  = ST_EMIT;
        end else if (opAvail) begin
          stb.advance  = 1'b1;
          stb.incCount = 1'b1;
        end else begin
          stb.nextPass = 1'b1;
        end
      end
      ST_EMIT: begin
        if (!passAvail) begin
          nextState = ST_FIN;
        end else if (opAvail) begin
          if (pairReady) begin
            stb.advance = 1'b1;
            stb.consume = 1'b1;
          end
        end else begin
          stb.nextPass = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign pairValid  = (state == ST_EMIT) && opAvail;
  assign countValid = (state == ST_EMIT);
  assign done       = (state == ST_FIN);

  // R8: a start pulse during streaming never restarts the count
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EMIT && start) |=> (state != ST_COUNT));

  // R6: done lasts one cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/tree_reduce_sched.sv
module tree_reduce_sched
  import tree_reduce_sched_pkg::*;
#(
  parameter int DIM_W   = 5,
  parameter int COUNT_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [DIM_W-1:0]   cfgDim,
  input  logic               pairReady,
  output logic               pairValid,
  output logic [DIM_W-1:0]   leftIdx,
  output logic [DIM_W-1:0]   rightIdx,
  output logic [DIM_W-1:0]   pairStride,
  output logic               pairLast,
  output logic [COUNT_W-1:0] opCount,
  output logic               countValid,
  output logic               done,
  output logic [1:0]         leftRole,
  output logic [1:0]         rightRole,
  output logic [1:0]         modeCode
);

  ctlStrobe_t stb;
  logic       opAvail;
  logic       passAvail;

  tree_reduce_sched_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .pairReady  (pairReady),
    .opAvail    (opAvail),
    .passAvail  (passAvail),
    .stb        (stb),
    .pairValid  (pairValid),
    .countValid (countValid),
    .done       (done)
  );

  tree_reduce_sched_dp #(
    .DIM_W   (DIM_W),
    .COUNT_W (COUNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgDim     (cfgDim),
    .opAvail    (opAvail),
    .passAvail  (passAvail),
    .leftIdx    (leftIdx),
    .rightIdx   (rightIdx),
    .pairStride (pairStride),
    .pairLast   (pairLast),
    .opCount    (opCount)
  );

  assign leftRole  = ROLE_LEFT;
  assign rightRole = ROLE_RIGHT;
  assign modeCode  = MODE_TREE;

  // R4: pair holds under backpressure
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !pairReady) |=> (pairValid && $stable(leftIdx) &&
      $stable(rightIdx) && $stable(pairStride) && $stable(pairLast)));

  // R2: left index is aligned to twice the stride
  assert_align_R2: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> ((({1'b0, leftIdx}) & ((({1'b0, pairStride}) << 1) - 1'b1)) == '0));

  // R6: quiet outputs while done is raised
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!pairValid && !countValid));

  // R5: nothing follows the final accepted pair
  assert_last_final_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && pairReady && pairLast) |=> !pairValid);

endmodule

// File: tb/tree_reduce_sched_tb.sv
`timescale 1ns/1ps
module tree_reduce_sched_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [4:0] cfgDim = '0;
  logic       pairReady = 1'b0;
  logic       pairValid;
  logic [4:0] leftIdx, rightIdx, pairStride;
  logic       pairLast;
  logic [6:0] opCount;
  logic       countValid, done;
  logic [1:0] leftRole, rightRole, modeCode;

  always #2 clk = ~clk;

  tree_reduce_sched u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cfgDim(cfgDim),
    .pairReady(pairReady), .pairValid(pairValid), .leftIdx(leftIdx),
    .rightIdx(rightIdx), .pairStride(pairStride), .pairLast(pairLast),
    .opCount(opCount), .countValid(countValid), .done(done),
    .leftRole(leftRole), .rightRole(rightRole), .modeCode(modeCode)
  );

  int vectors = 0;
  int errs = 0;
  int cycles = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  int expL[64];
  int expR[64];
  int expS[64];
  int expCnt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic buildExpected(input int n);
    expCnt = 0;
    for (int s = 1; s < n; s = s * 2)
      for (int b = 0; b + s < n; b = b + 2 * s) begin
        expL[expCnt] = b;
        expR[expCnt] = b + s;
        expS[expCnt] = s;
        expCnt++;
      end
  endtask

  task automatic runOne(input int d, input int mode);
    int  idx;
    bit  holdPend;
    int  hL, hR, hS, hLast;
    bit  seenCount;
    bit  injected;
    bit  r;
    buildExpected(d + 1);
    @(negedge clk);
    cfgDim = 5'(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfgDim = 5'(31 - d);
    seenCount = 0;
    for (int k = 0; k < 400 && !seenCount; k++) begin
      if (pairValid && !countValid) chk(0, "R3 pair before count", 1, 0);
      if (countValid) seenCount = 1;
      else @(negedge clk);
    end
    chk(seenCount, "R3 countValid rises", seenCount, 1);
    chk(opCount == 7'(expCnt), "R1 opCount", opCount, expCnt);
    chk(expCnt == d, "R1 count is N-1", expCnt, d);
    idx = 0; holdPend = 0; injected = 0;
    for (int k = 0; k < 2000; k++) begin
      start = 1'b0;
      if (holdPend)
        chk(pairValid && leftIdx == 5'(hL) && rightIdx == 5'(hR) &&
            pairStride == 5'(hS) && pairLast == hLast[0],
            "R4 hold", leftIdx, hL);
      if (done) begin
        chk(idx == expCnt, "R6 done after final pair", idx, expCnt);
        chk(!pairValid && !countValid, "R6 quiet during done", pairValid, 0);
        chk(opCount == 7'(expCnt), "R8 opCount kept", opCount, expCnt);
        if (d == 0) chk(idx == 0 && opCount == 0, "R7 single element", idx, 0);
        break;
      end
      if (mode == 2 && idx == 1 && !injected) begin
        start = 1'b1;
        cfgDim = 5'd2;
        injected = 1;
      end
      r = (mode == 0) ? 1'b1 : lfsr[0];
      pairReady = r;
      if (pairValid) begin
        if (idx >= expCnt) begin
          chk(0, "R2 extra pair", idx, expCnt);
        end else if (r) begin
          chk(leftIdx == 5'(expL[idx]), "R2 left", leftIdx, expL[idx]);
          chk(rightIdx == 5'(expR[idx]), "R2 right", rightIdx, expR[idx]);
          chk(pairStride == 5'(expS[idx]), "R2 stride", pairStride, expS[idx]);
          chk(pairLast == (idx == expCnt - 1), "R5 last flag", pairLast, idx == expCnt - 1);
          idx++;
          holdPend = 0;
        end else begin
          holdPend = 1;
          hL = leftIdx; hR = rightIdx; hS = pairStride; hLast = pairLast;
        end
      end else begin
        chk(!holdPend, "R4 valid dropped", 0, 1);
        holdPend = 0;
      end
      @(negedge clk);
    end
    pairReady = 1'b0;
    start = 1'b0;
    @(negedge clk);
    chk(!done, "R6 done single cycle", done, 0);
  endtask

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errs++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    #1;
    chk(!pairValid && !countValid && !done && opCount == 0, "R10 reset state", opCount, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!pairValid && !countValid && !done && opCount == 0, "R10 idle after reset", pairValid, 0);
    chk(leftRole == 2'b00, "R9 left role", leftRole, 0);
    chk(rightRole == 2'b01, "R9 right role", rightRole, 1);
    chk(modeCode == 2'b11, "R9 mode code", modeCode, 3);
    for (int d = 0; d < 32; d++) begin
      runOne(d, 0);
      runOne(d, 1);
      if (d >= 3) runOne(d, 2);
    end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

endmodule